// File: doc/BRIEF.md
# SPI Byte FIFO Pair with Event and Interrupt Logic

This block sits between a 32-bit register port and an SPI shift engine. Software writes whole words into a transmit byte FIFO. The shift engine takes those bytes out one at a time. In the other direction, the engine deposits received bytes one at a time. Software collects them either as whole words or, to drain a short final word of one to three bytes, one byte per read. Within any word, the byte in bits 31:24 is the first one on the wire.

An event word shows the live fill count of each FIFO, four level flags and four sticky error flags. The level flags are receive-not-empty, transmit-has-room, transmit-low and receive-high. A push into a FIFO without enough room is dropped, and so is a pop from a FIFO without enough bytes. Either one raises a sticky flag, and software clears these flags by writing ones to them. A mask register selects which of the low ten event bits drive the single interrupt line.

Register word addresses on `reg_addr`: 0 is the mode register (transmit threshold in bits 13:8, receive threshold in bits 5:0), 1 is the event register, 2 is the mask register, 3 is the transmit data register (write only) and 4 is the receive data register (read pops). Serial shifting, clock division and chip-select timing belong to other blocks.

Top module: `spi_fifo_evt`

## Requirements
- R1: After reset the mode register reads 0x00000403 (transmit threshold 4, receive threshold 3), the mask reads 0, the event word reads 0x00000102 and `irq` is low.
- R2: A write to address 3 pushes the four bytes of `reg_wdata`, bits 31:24 first. The engine sees the oldest byte on `eng_tx_byte` while `eng_tx_valid` is high, and `eng_tx_pop` removes it.
- R3: A read of address 4 with `reg_byte` low pops four bytes in the same cycle. The oldest byte is returned in bits 31:24 of `reg_rdata`.
- R4: A read of address 4 with `reg_byte` high pops one byte and returns it in bits 7:0, with bits 31:8 zero.
- R5: Event bits 29:24 hold the receive FIFO byte count and bits 21:16 hold the transmit FIFO byte count. Both are live.
- R6: Event bit 9 is set while the receive FIFO holds at least one byte. Event bit 8 is set while the transmit FIFO has room for a whole word (at least 4 free bytes).
- R7: Event bit 1 is set while the transmit count is at or below the transmit threshold. Event bit 0 is set while the receive count is above the receive threshold. Both thresholds are read and written through the mode register.
- R8: A word write with fewer than 4 free transmit bytes is dropped whole and sets sticky event bit 6. An engine push into a full receive FIFO is dropped and sets sticky event bit 4.
- R9: A receive read asking for more bytes than are held pops nothing, returns 0 and sets sticky event bit 7. An engine pop of an empty transmit FIFO sets sticky event bit 5.
- R10: Writing the event register clears each sticky bit (7:4) written as one. Zeros leave sticky bits unchanged, and the live bits and counts are unaffected.
- R11: `irq` is the OR of event bits 9:0 ANDed with mask bits 9:0. The mask register reads back only bits 9:0.
- R12: When a sticky event is raised in the same cycle as a write-one clear of that bit, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (receive reads pop at the clock edge) |
| reg_byte | input | 1 | Receive read takes one byte instead of four |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| eng_tx_pop | input | 1 | Engine takes the oldest transmit byte |
| eng_tx_valid | output | 1 | Transmit FIFO is not empty |
| eng_tx_byte | output | 8 | Oldest transmit byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| irq | output | 1 | Masked interrupt |

## Verification
The bench fills the transmit FIFO exactly to its 32-byte limit and then writes once more. A design that accepted a partial word there would corrupt the byte sequence the engine drains. A receive word read is made with only two bytes held, which catches a design that pops what it can and loses the tail. A sticky raise is driven in the same cycle as a write-all-ones clear: a design that lets the clear win would silently lose an overflow. Byte-mode reads, threshold changes and the interrupt masking are also checked at the boundaries where a flag flips, so an off-by-one in any count comparison shows up as a wrong event word.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
    localparam int LANES = 4;              // bytes per register word
    localparam int WORD_W = 8 * LANES;

    localparam logic [2:0] A_MODE  = 3'd0;
    localparam logic [2:0] A_EVENT = 3'd1;
    localparam logic [2:0] A_MASK  = 3'd2;
    localparam logic [2:0] A_TXD   = 3'd3;
    localparam logic [2:0] A_RXD   = 3'd4;

    localparam int THR_W = 6;

    // sticky index inside the 4-bit sticky vector (event bits 7:4)
    localparam int S_RX_OVF = 0;  // event bit 4
    localparam int S_TX_UNF = 1;  // event bit 5
    localparam int S_TX_OVF = 2;  // event bit 6
    localparam int S_RX_UNF = 3;  // event bit 7

    typedef struct packed {
        logic [THR_W-1:0] tx_thr;
        logic [THR_W-1:0] rx_thr;
    } mode_t;
endpackage

// File: rtl/sfe_byte_fifo.sv
module sfe_byte_fifo #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    parameter int CNT_W = $clog2(DEPTH) + 1,
    parameter int N_W   = $clog2(LANES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_W-1:0]     push_n,
    input  logic [8*LANES-1:0] push_data,
    input  logic [N_W-1:0]     pop_n,
    output logic               push_ok,
    output logic               pop_ok,
    output logic [8*LANES-1:0] head_data,
    output logic [CNT_W-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] mem;
        logic [PTR_W-1:0]      wptr;
        logic [PTR_W-1:0]      rptr;
        logic [CNT_W-1:0]      cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        push_ok = (SUM_W'(s_q.cnt) + SUM_W'(push_n)) <= SUM_W'(DEPTH);
        pop_ok  = SUM_W'(s_q.cnt) >= SUM_W'(pop_n);
        if (push_ok) begin
            for (int i = 0; i < LANES; i++) begin
                if (i < int'(push_n)) begin
                    s_d.mem[s_q.wptr + PTR_W'(i)] = push_data[8*(LANES-1-i) +: 8];
                end
            end
            s_d.wptr = s_q.wptr + PTR_W'(push_n);
        end
        if (pop_ok) begin
            s_d.rptr = s_q.rptr + PTR_W'(pop_n);
        end
        s_d.cnt = s_q.cnt + (push_ok ? CNT_W'(push_n) : '0)
                          - (pop_ok  ? CNT_W'(pop_n)  : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_head
        assign head_data[8*(LANES-1-g) +: 8] = s_q.mem[s_q.rptr + PTR_W'(g)];
    end

    assign count = s_q.cnt;

    // R8: the fill count never exceeds the storage
    a_r8_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    // R8: a refused push with no pop leaves the count alone
    a_r8_refused_push_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n != '0 && !push_ok && pop_n == '0) |=> $stable(s_q.cnt));

    // R9: a refused pop with no push leaves the count alone
    a_r9_refused_pop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_n != '0 && !pop_ok && push_n == '0) |=> $stable(s_q.cnt));
endmodule

// File: rtl/sfe_evt_unit.sv
module sfe_evt_unit #(
    parameter int DEPTH = 32,
    parameter int LANES = 4,
    parameter int CNT_W = $clog2(DEPTH) + 1,
    parameter int THR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] tx_cnt,
    input  logic [CNT_W-1:0] rx_cnt,
    input  logic [THR_W-1:0] tx_thr,
    input  logic [THR_W-1:0] rx_thr,
    input  logic [3:0]       sticky_set,
    input  logic             clr_wr,
    input  logic [3:0]       clr_bits,
    input  logic             mask_wr,
    input  logic [9:0]       mask_wdata,
    output logic [31:0]      event_word,
    output logic [31:0]      mask_word,
    output logic             irq
);
    typedef struct packed {
        logic [3:0] sticky;
        logic [9:0] mask;
    } evt_state_t;

    evt_state_t s_d, s_q;
    logic rx_ne, tx_room, tx_low, rx_high;

    always_comb begin
        s_d        = s_q;
        s_d.sticky = (s_q.sticky & ~(clr_wr ? clr_bits : 4'b0)) | sticky_set;
        if (mask_wr) s_d.mask = mask_wdata;

        rx_ne   = rx_cnt != '0;
        tx_room = tx_cnt <= CNT_W'(DEPTH - LANES);
        tx_low  = 8'(tx_cnt) <= 8'(tx_thr);
        rx_high = 8'(rx_cnt) >  8'(rx_thr);

        event_word        = '0;
        event_word[29:24] = 6'(rx_cnt);
        event_word[21:16] = 6'(tx_cnt);
        event_word[9]     = rx_ne;
        event_word[8]     = tx_room;
        event_word[7:4]   = s_q.sticky;
        event_word[1]     = tx_low;
        event_word[0]     = rx_high;

        mask_word       = '0;
        mask_word[9:0]  = s_q.mask;
        irq             = |(event_word[9:0] & s_q.mask);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R10: sticky bits hold when nothing sets or clears them
    a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_wr && sticky_set == 4'b0) |=> $stable(s_q.sticky));

    // R12: a raised sticky bit is set after the edge whatever the clear did
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (sticky_set != 4'b0) |=> ((s_q.sticky & $past(sticky_set)) == $past(sticky_set)));

    // R11: an all-zero mask keeps the line low
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mask == 10'b0) |-> !irq);
endmodule

// File: rtl/spi_fifo_evt.sv
module spi_fifo_evt
    import sfe_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_rd,
    input  logic        reg_byte,
    input  logic [2:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        eng_tx_pop,
    output logic        eng_tx_valid,
    output logic [7:0]  eng_tx_byte,
    input  logic        eng_rx_push,
    input  logic [7:0]  eng_rx_byte,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH) + 1;
    localparam int N_W   = $clog2(LANES) + 1;

    mode_t mode_d, mode_q;

    logic wr_mode, wr_evt, wr_mask, wr_tx, rd_rx;
    logic [N_W-1:0] tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
    logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok;
    logic [WORD_W-1:0] tx_head, rx_head, rx_push_word;
    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic [3:0]  sticky_set;
    logic [31:0] event_word, mask_word;

    always_comb begin
        wr_mode = reg_wr && reg_addr == A_MODE;
        wr_evt  = reg_wr && reg_addr == A_EVENT;
        wr_mask = reg_wr && reg_addr == A_MASK;
        wr_tx   = reg_wr && reg_addr == A_TXD;
        rd_rx   = reg_rd && reg_addr == A_RXD;

        tx_push_n    = wr_tx ? N_W'(LANES) : '0;
        tx_pop_n     = eng_tx_pop ? N_W'(1) : '0;
        rx_push_n    = eng_rx_push ? N_W'(1) : '0;
        rx_push_word = {eng_rx_byte, {(WORD_W-8){1'b0}}};
        rx_pop_n     = rd_rx ? (reg_byte ? N_W'(1) : N_W'(LANES)) : '0;

        sticky_set           = '0;
        sticky_set[S_RX_OVF] = eng_rx_push && !rx_push_ok;
        sticky_set[S_TX_UNF] = eng_tx_pop  && !tx_pop_ok;
        sticky_set[S_TX_OVF] = wr_tx       && !tx_push_ok;
        sticky_set[S_RX_UNF] = rd_rx       && !rx_pop_ok;

        mode_d = mode_q;
        if (wr_mode) begin
            mode_d.tx_thr = reg_wdata[8 +: THR_W];
            mode_d.rx_thr = reg_wdata[0 +: THR_W];
        end

        reg_rdata = '0;
        if (reg_rd) begin
            unique case (reg_addr)
                A_MODE: begin
                    reg_rdata[8 +: THR_W] = mode_q.tx_thr;
                    reg_rdata[0 +: THR_W] = mode_q.rx_thr;
                end
                A_EVENT: reg_rdata = event_word;
                A_MASK:  reg_rdata = mask_word;
                A_RXD: begin
                    if (rx_pop_ok) begin
                        if (reg_byte) reg_rdata[7:0] = rx_head[WORD_W-1 -: 8];
                        else          reg_rdata      = rx_head;
                    end
                end
                default: reg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '{tx_thr: THR_W'(4), rx_thr: THR_W'(3)};
        else        mode_q <= mode_d;
    end

    sfe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W), .N_W(N_W)) u_txq (
        .clk(clk), .rst_n(rst_n),
        .push_n(tx_push_n), .push_data(reg_wdata), .pop_n(tx_pop_n),
        .push_ok(tx_push_ok), .pop_ok(tx_pop_ok),
        .head_data(tx_head), .count(tx_cnt)
    );

    sfe_byte_fifo #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W), .N_W(N_W)) u_rxq (
        .clk(clk), .rst_n(rst_n),
        .push_n(rx_push_n), .push_data(rx_push_word), .pop_n(rx_pop_n),
        .push_ok(rx_push_ok), .pop_ok(rx_pop_ok),
        .head_data(rx_head), .count(rx_cnt)
    );

    sfe_evt_unit #(.DEPTH(DEPTH), .LANES(LANES), .CNT_W(CNT_W), .THR_W(THR_W)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .tx_cnt(tx_cnt), .rx_cnt(rx_cnt),
        .tx_thr(mode_q.tx_thr), .rx_thr(mode_q.rx_thr),
        .sticky_set(sticky_set),
        .clr_wr(wr_evt), .clr_bits(reg_wdata[7:4]),
        .mask_wr(wr_mask), .mask_wdata(reg_wdata[9:0]),
        .event_word(event_word), .mask_word(mask_word), .irq(irq)
    );

    assign eng_tx_valid = tx_cnt != '0;
    assign eng_tx_byte  = tx_head[WORD_W-1 -: 8];

    // R2: an accepted word with no engine pop grows the transmit count by four
    a_r2_word_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_push_ok && !eng_tx_pop) |=> (tx_cnt == $past(tx_cnt) + CNT_W'(LANES)));

    // R3: an accepted word read with no engine push shrinks the receive count by four
    a_r3_word_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !reg_byte && rx_pop_ok && !eng_rx_push) |=> (rx_cnt == $past(rx_cnt) - CNT_W'(LANES)));
endmodule

// File: tb/sim_spi_fifo_evt.sv
module sim_spi_fifo_evt;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_byte = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eng_tx_pop = 1'b0;
    logic        eng_tx_valid;
    logic [7:0]  eng_tx_byte;
    logic        eng_rx_push = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    spi_fifo_evt u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_byte(reg_byte),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_valid(eng_tx_valid), .eng_tx_byte(eng_tx_byte),
        .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte), .irq(irq)
    );

    // op: 0 register write, 1 word read check, 2 byte read check,
    //     3 engine receive push, 4 engine transmit pop with byte check
    // fields: {op, requirement, addr, data, expected}
    localparam int NV = 25;
    localparam logic [75:0] VEC [NV] = '{
        {4'd0, 4'd2,  4'd3, 32'hA1B2C3D4, 32'h0},          // R2 word in
        {4'd1, 4'd5,  4'd1, 32'h0,        32'h00040102},   // R5 R6 R7 counts and flags
        {4'd4, 4'd2,  4'd0, 32'h0,        32'h000000A1},   // R2 MSB first
        {4'd4, 4'd2,  4'd0, 32'h0,        32'h000000B2},
        {4'd3, 4'd3,  4'd0, 32'h11,       32'h0},
        {4'd3, 4'd3,  4'd0, 32'h22,       32'h0},
        {4'd3, 4'd3,  4'd0, 32'h33,       32'h0},
        {4'd1, 4'd7,  4'd1, 32'h0,        32'h03020302},   // R7 rx 3 not above 3
        {4'd3, 4'd3,  4'd0, 32'h44,       32'h0},
        {4'd1, 4'd7,  4'd1, 32'h0,        32'h04020303},   // R7 rx 4 above 3
        {4'd1, 4'd3,  4'd4, 32'h0,        32'h11223344},   // R3 word read
        {4'd3, 4'd4,  4'd0, 32'h55,       32'h0},
        {4'd3, 4'd4,  4'd0, 32'h66,       32'h0},
        {4'd2, 4'd4,  4'd4, 32'h0,        32'h00000055},   // R4 byte read
        {4'd2, 4'd4,  4'd4, 32'h0,        32'h00000066},
        {4'd1, 4'd6,  4'd1, 32'h0,        32'h00020102},   // R6 rx empty
        {4'd0, 4'd7,  4'd0, 32'h00000100, 32'h0},          // R7 thresholds 1 / 0
        {4'd1, 4'd7,  4'd1, 32'h0,        32'h00020100},
        {4'd3, 4'd7,  4'd0, 32'h77,       32'h0},
        {4'd1, 4'd7,  4'd1, 32'h0,        32'h01020301},
        {4'd1, 4'd7,  4'd0, 32'h0,        32'h00000100},   // R7 mode readback
        {4'd2, 4'd4,  4'd4, 32'h0,        32'h00000077},
        {4'd4, 4'd2,  4'd0, 32'h0,        32'h000000C3},
        {4'd4, 4'd2,  4'd0, 32'h0,        32'h000000D4},
        {4'd1, 4'd5,  4'd1, 32'h0,        32'h00000102}    // R5 both empty
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic bmode, input string req, input logic [31:0] exp);
        reg_rd = 1'b1; reg_addr = a; reg_byte = bmode;
        #1 check(req, reg_rdata, exp);
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0; reg_byte = 1'b0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        eng_rx_push = 1'b1; eng_rx_byte = b;
        @(posedge clk); @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    task automatic tx_pop(input string req, input logic [7:0] exp);
        #1 check(req, {24'h0, eng_tx_byte}, {24'h0, exp});
        eng_tx_pop = 1'b1;
        @(posedge clk); @(negedge clk);
        eng_tx_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd0, 1'b0, "R1", 32'h00000403);
        rd(3'd2, 1'b0, "R1", 32'h0);
        rd(3'd1, 1'b0, "R1", 32'h00000102);
        check("R1", {31'h0, irq}, 32'h0);

        for (int k = 0; k < NV; k++) begin
            logic [3:0]  op, rq, ad;
            logic [31:0] dt, ex;
            {op, rq, ad, dt, ex} = VEC[k];
            case (op)
                4'd0: wr(ad[2:0], dt);
                4'd1: rd(ad[2:0], 1'b0, $sformatf("R%0d", rq), ex);
                4'd2: rd(ad[2:0], 1'b1, $sformatf("R%0d", rq), ex);
                4'd3: rx_push(dt[7:0]);
                default: tx_pop($sformatf("R%0d", rq), ex[7:0]);
            endcase
        end

        // R8 fill the transmit FIFO to its limit, then overflow it
        for (int w = 0; w < 8; w++) begin
            wr(3'd3, {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)});
            if (w == 6) rd(3'd1, 1'b0, "R6", 32'h001C0100);
        end
        rd(3'd1, 1'b0, "R6", 32'h00200000);
        wr(3'd3, 32'hDEADBEEF);
        rd(3'd1, 1'b0, "R8", 32'h00200040);
        for (int b = 0; b < 32; b++) tx_pop("R2", 8'(b));
        check("R2", {31'h0, eng_tx_valid}, 32'h0);
        // R9 engine pop of empty transmit FIFO
        eng_tx_pop = 1'b1;
        @(posedge clk); @(negedge clk);
        eng_tx_pop = 1'b0;
        rd(3'd1, 1'b0, "R9", 32'h00000162);

        // R9 receive underflow: empty, then short word
        rd(3'd4, 1'b0, "R9", 32'h0);
        rd(3'd1, 1'b0, "R9", 32'h000001E2);
        rx_push(8'hAA);
        rx_push(8'hBB);
        rd(3'd4, 1'b0, "R9", 32'h0);
        rd(3'd1, 1'b0, "R9", 32'h020003E3);
        rd(3'd4, 1'b1, "R4", 32'h000000AA);
        rd(3'd4, 1'b1, "R4", 32'h000000BB);

        // R10 write-one-to-clear
        wr(3'd1, 32'h00000020);
        rd(3'd1, 1'b0, "R10", 32'h000001C2);
        wr(3'd1, 32'h0);
        rd(3'd1, 1'b0, "R10", 32'h000001C2);
        wr(3'd1, 32'hFFFFFFFF);
        rd(3'd1, 1'b0, "R10", 32'h00000102);

        // R8 receive overflow
        for (int b = 0; b < 33; b++) rx_push(8'(b));
        rd(3'd1, 1'b0, "R8", 32'h20000313);

        // R12 raise and clear in the same cycle
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 32'hFFFFFFFF;
        eng_rx_push = 1'b1; eng_rx_byte = 8'hEE;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0; eng_rx_push = 1'b0;
        rd(3'd1, 1'b0, "R12", 32'h20000313);
        wr(3'd1, 32'hFFFFFFFF);
        rd(3'd1, 1'b0, "R10", 32'h20000303);

        // R11 interrupt masking
        check("R11", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'h00000200);
        rd(3'd2, 1'b0, "R11", 32'h00000200);
        check("R11", {31'h0, irq}, 32'h1);
        for (int w = 0; w < 8; w++)
            rd(3'd4, 1'b0, "R3", {8'(4*w), 8'(4*w+1), 8'(4*w+2), 8'(4*w+3)});
        check("R11", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'hFFFFFFFF);
        rd(3'd2, 1'b0, "R11", 32'h000003FF);
        check("R11", {31'h0, irq}, 32'h1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule